// File: doc/BRIEF.md
# Real-Time-Clock Timebase with Periodic-Rate Tap

This block turns a 32.768 kHz oscillator clock into the timing events of a real-time clock. A 15-stage binary divider chain, one clock cycle per oscillator period, produces a one-cycle update strobe once per second. The strobe advances the calendar counters that sit outside this block. A second output, a one-cycle periodic pulse, comes from one of the chain's taps, chosen by software. It feeds an interrupt-flag register that an enable elsewhere may gate. An update-in-progress status bit warns software ahead of each update, so that calendar reads taken while it is low are safe.

Software reaches the block through a small read/write port. The 8-bit control register holds a 3-bit chain-mode field in bits 6:4 and a 4-bit rate field in bits 3:0. Bit 7 reads back the live status bit and has no write lane. System reset does not touch the control register. It only returns the chain and the status logic to their idle states.

Two state machines carry the behaviour. The chain machine has the states CH_CLEAR (counter held at its half-way preload), CH_RUN (counting) and CH_STALL (counter frozen). Each cycle it moves to the state that the mode field names: codes 110/111 lead to CH_CLEAR, codes 010..101 to CH_RUN, and codes 000/001 to CH_STALL, so any state can reach any other. The status machine has UP_IDLE, UP_WARN and UP_BUSY. It takes UP_IDLE→UP_WARN when the count enters the warning window, UP_WARN→UP_BUSY on the update strobe, and UP_BUSY→UP_IDLE after the hold count. It leaves either of the active states for UP_IDLE as soon as the chain is not running in normal mode.

Top module: `rtc_timebase`

## Requirements
- R1: A write stores wr_data[6:4] as the mode field and wr_data[3:0] as the rate field. rd_data returns {status bit, mode, rate}. The stored fields survive any assertion of rst_n.
- R2: Mode 110 or 111 holds the chain cleared. No update strobe and no periodic pulse occur, and the status bit stays 0.
- R3: After mode 010 is written over a cleared chain, the first update strobe is high in the 16384th cycle after the write edge (500 ms).
- R4: In mode 010 the update strobe is high for exactly one cycle, every 32768 cycles.
- R5: Modes 011, 100 and 101 skip 5, 10 and 15 low stages. The update strobe then repeats every 1024 cycles, every 32 cycles, or in every cycle.
- R6: Mode 000 or 001 freezes the chain with no strobe and no pulse. A return to mode 010 resumes counting from the frozen value.
- R7: In mode 010, rate code n from 3 to 15 gives a one-cycle periodic pulse every 2^(n-1) cycles (code 3: 4 cycles, code 15: 16384 cycles).
- R8: Rate codes 1 and 2 behave as codes 8 and 9, with periods of 128 and 256 cycles.
- R9: Rate code 0 produces no periodic pulse.
- R10: A write produces no periodic pulse in the following cycle. After a rate change, the first pulse comes on the next rising edge of the newly chosen tap, within one new period.
- R11: In mode 010 the status bit rises 16 cycles before the cycle in which the update strobe is high. While it is low, no strobe comes in the next cycle.
- R12: The status bit stays high for 8 cycles after the strobe cycle and then falls.
- R13: While rst_n is low and after its release, the update strobe, the periodic pulse and the status bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock, one cycle per divider input period |
| rst_n | input | 1 | Active-low synchronous reset of chain and status logic |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 7 | Write data: [6:4] mode, [3:0] rate |
| rd_data | output | 8 | Read data: [7] status bit, [6:4] mode, [3:0] rate |
| upd_tick_o | output | 1 | One-cycle update strobe, once per chain wrap |
| periodic_o | output | 1 | One-cycle pulse on each rising edge of the selected tap |
| uip_o | output | 1 | Update-in-progress status bit |

## Verification
The rate generator is driven through a table of rate codes. Low, middle and aliased codes are mixed so that a wrong tap index, a missing alias, or a tap off by one stage each show up as a different measured period. The update path is tried in three patterns: a release from the cleared state, which separates the half-way preload from a preload to zero; a freeze and resume, which separates holding the count from reloading it; and each skip mode, which separates the three step sizes. A mid-run rate switch shows whether the tap change leaks a stray pulse or waits too long.

// File: rtl/rtc_tbase_pkg.sv
`timescale 1ns/1ps
package rtc_tbase_pkg;

    typedef enum logic [1:0] {
        CH_CLEAR = 2'd0,
        CH_RUN   = 2'd1,
        CH_STALL = 2'd2
    } chain_state_e;

    typedef enum logic [1:0] {
        UP_IDLE = 2'd0,
        UP_WARN = 2'd1,
        UP_BUSY = 2'd2
    } upd_state_e;

    localparam logic [2:0] MODE_NORMAL = 3'b010;
    localparam logic [2:0] MODE_SKIP_A = 3'b011;
    localparam logic [2:0] MODE_SKIP_B = 3'b100;
    localparam logic [2:0] MODE_SKIP_C = 3'b101;

    // Chain state named by a mode code
    function automatic chain_state_e mode_state(input logic [2:0] mode);
        case (mode)
            MODE_NORMAL, MODE_SKIP_A, MODE_SKIP_B, MODE_SKIP_C: return CH_RUN;
            3'b110, 3'b111:                                       return CH_CLEAR;
            default:                                              return CH_STALL;
        endcase
    endfunction

    // Number of low stages skipped for a mode code
    function automatic int mode_skip(input logic [2:0] mode, input int unit);
        case (mode)
            MODE_SKIP_A: return unit;
            MODE_SKIP_B: return 2 * unit;
            MODE_SKIP_C: return 3 * unit;
            default:     return 0;
        endcase
    endfunction

    // Counter bit watched for a rate code; low codes alias higher ones
    function automatic logic [4:0] rate_bit(input logic [3:0] code);
        case (code)
            4'd1:    return 5'd6;
            4'd2:    return 5'd7;
            default: return {1'b0, code} - 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/rtc_div_ctrl.sv
`timescale 1ns/1ps
module rtc_div_ctrl
    import rtc_tbase_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [6:0]   wr_data,
    output logic [2:0]   mode_o,
    output logic [3:0]   rate_o,
    output chain_state_e state_o
);

    logic [2:0]   mode_q;
    logic [3:0]   rate_q;
    chain_state_e st_q, st_nxt;

    // Control fields: kept across system reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mode_q <= wr_data[6:4];
            rate_q <= wr_data[3:0];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_CLEAR;
        else        st_q <= st_nxt;
    end

    // Next state and outputs
    always_comb begin
        st_nxt  = mode_state(mode_q);
        mode_o  = mode_q;
        rate_o  = rate_q;
        state_o = st_q;
    end

    // R2: a clearing mode reaches CH_CLEAR one cycle after the write lands
    assert_clear_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6:5] == 2'b11) |=> ##1 (st_q == CH_CLEAR));

    // R6: a freezing mode reaches CH_STALL one cycle after the write lands
    assert_stall_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6:5] == 2'b00) |=> ##1 (st_q == CH_STALL));

endmodule

// File: rtl/rtc_div_chain.sv
`timescale 1ns/1ps
module rtc_div_chain
    import rtc_tbase_pkg::*;
#(
    parameter int N        = 15,
    parameter int BYP_UNIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  chain_state_e state_i,
    input  logic [2:0]   mode_i,
    output logic [N-1:0] cnt_o,
    output logic [N-1:0] cnt_nxt_o,
    output logic         tick_o
);

    localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};
    localparam logic [N:0]   ONE  = {{N{1'b0}}, 1'b1};

    logic [N-1:0] cnt_q;
    logic [N:0]   step;
    logic [N:0]   sum;

    always_comb begin
        step = ONE << mode_skip(mode_i, BYP_UNIT);
        sum  = {1'b0, cnt_q} + step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= HALF;
        end else begin
            unique case (state_i)
                CH_CLEAR: cnt_q <= HALF;
                CH_RUN:   cnt_q <= sum[N-1:0];
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        tick_o    = (state_i == CH_RUN) && sum[N];
        cnt_o     = cnt_q;
        cnt_nxt_o = (state_i == CH_RUN) ? sum[N-1:0] : cnt_q;
    end

    // R2/R3: a cleared chain holds the half-way preload
    assert_clear_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == CH_CLEAR) |=> (cnt_q == HALF));

    // R6: a stalled chain keeps its count
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == CH_STALL) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_div_rate.sv
`timescale 1ns/1ps
module rtc_div_rate #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         wr_en,
    input  logic [3:0]   rate_i,
    input  logic [N-1:0] cnt_i,
    input  logic [N-1:0] cnt_nxt_i,
    output logic         pulse_o
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] tap_mask;
    logic         rise;
    logic         pulse_q;

    // Taps beyond the chain shift out of the mask and stay silent
    always_comb begin
        tap_mask = (rate_i != 4'd0) ? (ONE << rtc_tbase_pkg::rate_bit(rate_i)) : '0;
        rise     = run_i && (|(~cnt_i & cnt_nxt_i & tap_mask));
    end

    // A write cycle drops the edge so a tap swap cannot leak a pulse
    always_ff @(posedge clk) begin
        if (!rst_n)     pulse_q <= 1'b0;
        else if (wr_en) pulse_q <= 1'b0;
        else            pulse_q <= rise;
    end

    assign pulse_o = pulse_q;

    // R7: pulses are single cycles
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    // R9: code 0 is silent
    assert_code_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == 4'd0 && !wr_en) |=> !pulse_q);

    // R10: no pulse right after a write
    assert_no_pulse_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !pulse_q);

endmodule

// File: rtl/rtc_div_uip.sv
`timescale 1ns/1ps
module rtc_div_uip
    import rtc_tbase_pkg::*;
#(
    parameter int N    = 15,
    parameter int LEAD = 16,
    parameter int HOLD = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic [N-1:0] cnt_i,
    input  logic         tick_i,
    output logic         uip_o
);

    localparam int              WARN_INT  = (1 << N) - LEAD - 2;
    localparam logic [N-1:0]    WARN_AT   = WARN_INT[N-1:0];
    localparam int              HW        = $clog2(HOLD + 1);
    localparam int              HOLD_M1   = HOLD - 1;
    localparam logic [HW-1:0]   HOLD_LAST = HOLD_M1[HW-1:0];
    localparam logic [HW-1:0]   H_ONE     = {{(HW-1){1'b0}}, 1'b1};

    upd_state_e    st_q, st_nxt;
    logic [HW-1:0] hold_q, hold_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= UP_IDLE;
            hold_q <= '0;
        end else begin
            st_q   <= st_nxt;
            hold_q <= hold_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt   = st_q;
        hold_nxt = '0;
        if (!active_i) begin
            st_nxt = UP_IDLE;
        end else begin
            unique case (st_q)
                UP_IDLE: if (cnt_i >= WARN_AT) st_nxt = UP_WARN;
                UP_WARN: if (tick_i)           st_nxt = UP_BUSY;
                UP_BUSY: begin
                    if (hold_q == HOLD_LAST) st_nxt = UP_IDLE;
                    else                     hold_nxt = hold_q + H_ONE;
                end
                default: st_nxt = UP_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        uip_o = (st_q != UP_IDLE);
    end

    // R11: while idle below the window, no strobe can follow in normal mode
    assert_warn_before_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == UP_IDLE && active_i && cnt_i < WARN_AT) |=> !(active_i && tick_i));

    // R12: the hold count never passes its limit
    assert_hold_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == UP_BUSY) |-> (hold_q <= HOLD_LAST));

endmodule

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase
    import rtc_tbase_pkg::*;
#(
    parameter int STAGES   = 15,
    parameter int BYP_UNIT = 5,
    parameter int UIP_LEAD = 16,
    parameter int UIP_HOLD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [6:0] wr_data,
    output logic [7:0] rd_data,
    output logic       upd_tick_o,
    output logic       periodic_o,
    output logic       uip_o
);

    logic [2:0]        mode;
    logic [3:0]        rate;
    chain_state_e      ch_state;
    logic [STAGES-1:0] cnt, cnt_nxt;
    logic              tick, run, active, uip;

    rtc_div_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mode_o  (mode),
        .rate_o  (rate),
        .state_o (ch_state)
    );

    rtc_div_chain #(.N(STAGES), .BYP_UNIT(BYP_UNIT)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (ch_state),
        .mode_i    (mode),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .tick_o    (tick)
    );

    always_comb begin
        run    = (ch_state == CH_RUN);
        active = run && (mode == MODE_NORMAL);
    end

    rtc_div_rate #(.N(STAGES)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .wr_en     (wr_en),
        .rate_i    (rate),
        .cnt_i     (cnt),
        .cnt_nxt_i (cnt_nxt),
        .pulse_o   (periodic_o)
    );

    rtc_div_uip #(.N(STAGES), .LEAD(UIP_LEAD), .HOLD(UIP_HOLD)) u_uip (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .cnt_i    (cnt),
        .tick_i   (tick),
        .uip_o    (uip)
    );

    always_comb begin
        upd_tick_o = tick;
        uip_o      = uip;
        rd_data    = {uip, mode, rate};
    end

endmodule

// File: tb/rtc_timebase_test.sv
`timescale 1ns/1ps
module rtc_timebase_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [6:0] wr_data;
    logic [7:0] rd_data;
    logic       tick, pf, uip;

    int checks = 0;
    int errors = 0;
    int pf_seen = 0;

    // {rate code, expected period in cycles}, normal mode
    localparam logic [19:0] RATE_VEC [10] = '{
        {4'd3,  16'd4},    {4'd1,  16'd128}, {4'd6,  16'd32},
        {4'd2,  16'd256},  {4'd4,  16'd8},   {4'd5,  16'd16},
        {4'd8,  16'd128},  {4'd9,  16'd256}, {4'd10, 16'd512},
        {4'd12, 16'd2048}
    };

    rtc_timebase uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .upd_tick_o (tick),
        .periodic_o (pf),
        .uip_o      (uip)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (pf) pf_seen++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // sel: 0 strobe, 1 pulse, 2 status high, 3 status low
    task automatic wait_sig(input int sel, input int limit, output int n);
        bit hit;
        n = 0;
        hit = 1'b0;
        while (!hit && n < limit) begin
            @(negedge clk);
            n++;
            case (sel)
                0:       hit = tick;
                1:       hit = pf;
                2:       hit = uip;
                default: hit = !uip;
            endcase
        end
    endtask

    task automatic count_events(input int cycles, output int nt, output int np);
        nt = 0;
        np = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (tick) nt++;
            if (pf)   np++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n1, n2, n3, n4, nt, np, p0;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        wr(7'h65);                       // mode 110, rate 5, written under reset
        repeat (2) @(negedge clk);
        chk(!tick && !pf && !uip, "R13 outputs in reset", {tick, pf, uip}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h65, "R1 readback", rd_data, 8'h65);
        chk(!tick && !pf && !uip, "R13 outputs after release", {tick, pf, uip}, 0);

        count_events(2000, nt, np);
        chk(nt == 0 && np == 0, "R2 cleared chain quiet", nt + np, 0);
        chk(!uip, "R2 status low while cleared", uip, 0);

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h65, "R1 fields survive reset", rd_data, 8'h65);

        // Release to normal mode with rate 0
        p0 = pf_seen;
        wr(7'h20);
        wait_sig(2, 40000, n1);
        wait_sig(0, 100, n2);
        chk(n1 + n2 == 16384, "R3 first strobe delay", n1 + n2, 16384);
        chk(n2 == 16, "R11 status lead", n2, 16);
        wait_sig(3, 100, n3);
        chk(n3 == 9, "R12 status fall after strobe", n3, 9);
        wait_sig(0, 40000, n4);
        chk(n3 + n4 == 32768, "R4 strobe period", n3 + n4, 32768);
        @(negedge clk);
        chk(!tick, "R4 strobe one cycle", tick, 0);
        chk(pf_seen == p0, "R9 code 0 silent", pf_seen - p0, 0);

        // Rate table: R7 for codes 3..15, R8 for aliases 1 and 2
        for (int i = 0; i < 10; i++) begin
            logic [3:0] code;
            int per;
            code = RATE_VEC[i][19:16];
            per  = int'(RATE_VEC[i][15:0]);
            wr({3'b010, code});
            wait_sig(1, 5000, n1);
            wait_sig(1, 5000, n2);
            if (code < 4'd3) chk(n2 == per, "R8 aliased rate period", n2, per);
            else             chk(n2 == per, "R7 rate period", n2, per);
        end

        // R10: switch from a slow tap to the fastest one
        wr(7'h2C);
        wait_sig(1, 5000, n1);
        repeat (100) @(negedge clk);
        wr(7'h23);
        chk(!pf, "R10 no pulse after write", pf, 0);
        wait_sig(1, 20, n1);
        chk(n1 >= 1 && n1 <= 4, "R10 first pulse of new tap", n1, 4);
        wait_sig(1, 20, n2);
        chk(n2 == 4, "R10 new tap period", n2, 4);

        // R6: freeze and resume
        wr(7'h60);
        repeat (3) @(negedge clk);
        wr(7'h20);
        repeat (1000) @(negedge clk);
        wr(7'h00);
        count_events(500, nt, np);
        chk(nt == 0 && np == 0, "R6 frozen chain quiet", nt + np, 0);
        wr(7'h20);
        wait_sig(0, 40000, n1);
        chk(n1 == 15383, "R6 resume keeps count", n1, 15383);

        // R5: skip modes
        wr(7'h30);
        wait_sig(0, 3000, n1);
        wait_sig(0, 3000, n2);
        chk(n2 == 1024, "R5 skip 5 strobe period", n2, 1024);
        wr(7'h40);
        wait_sig(0, 100, n1);
        wait_sig(0, 100, n2);
        chk(n2 == 32, "R5 skip 10 strobe period", n2, 32);
        wr(7'h50);
        nt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (tick) nt++;
        end
        chk(nt == 4, "R5 skip 15 strobe every cycle", nt, 4);

        // R2: the other clearing code
        wr(7'h70);
        repeat (2) @(negedge clk);
        count_events(300, nt, np);
        chk(nt == 0 && np == 0, "R2 code 111 quiet", nt + np, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule